// File: doc/BRIEF.md
# Snoop Backoff and Flush Controller

This block is the coherence side of a small write-back data cache that sits next to other bus masters. Each line is tracked as Invalid, Shared, Exclusive or Modified. A line holds one data word. The local processor reads and writes through a simple request port, and lines are allocated only when a read misses. A write can be marked write-through per access, in which case memory is updated at once.

Another master's access is presented on a snoop port. It may hit a line that is held Modified here. In that case the block does not hand the data over. It raises a backoff signal in the same cycle, so that the other master abandons its cycle. In the next cycle the block writes the dirty word back to main memory. The other master then issues its request again and is served by memory.

A snoop that hits a clean line changes the line's state quietly. Replacement within a four-way set uses a three-bit tree pseudo-LRU.

Top module: `snoop_flush_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid and every tree is 3'b000. The backoff output is low, and every processor access misses.
- R2: A valid snoop whose address matches a Modified line raises `snp_backoff` in that same cycle, while no flush is in progress.
- R3: In the cycle after a backoff for a Modified hit, the block writes the line's tag-and-index address and its data to memory with `mem_we`. At the end of that cycle the line becomes Shared if the snoop was a read and Invalid if it was a write.
- R4: During the flush cycle any valid snoop is answered with `snp_backoff`, and that snoop changes no line state.
- R5: A snoop hit on a clean line raises no backoff. A write snoop makes the line Invalid, and a read snoop turns Exclusive into Shared.
- R6: `cpu_ready` is low while a snoop is presented or a flush is in progress, and the processor request then has no effect.
- R7: A read miss fills the chosen way from `mem_rdata` and returns that word on `cpu_rdata`. The line becomes Exclusive for a write-back access (`cpu_wt`=0) or Shared for a write-through one.
- R8: A write-back write hit on an Exclusive or Modified line updates the line and makes it Modified without a memory write. A write hit that is write-through, or that lands on a Shared line, writes memory and leaves the line Shared.
- R9: A write miss writes memory at `cpu_addr` and allocates no line.
- R10: A read miss takes the lowest-numbered Invalid way. If there is none, it takes the tree victim: bit0=0 picks ways 0/1, where bit1 picks way 1 over way 0, and bit0=1 picks ways 2/3, where bit2 picks way 3 over way 2. A Modified victim is written to memory in the same cycle.
- R11: Every read hit, write hit and fill to way w updates the tree so that it points away from w. For w<2 this sets bit0=1 and bit1=(w==0). For w>=2 it sets bit0=0 and bit2=(w==2).
- R12: A line address is held in at most one way of its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wt | input | 1 | Access uses write-through policy |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the set |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_hit | output | 1 | Processor address matches a valid line |
| cpu_rdata | output | DATA_W | Line data on hit, memory data on miss |
| snp_valid | input | 1 | External master access presented |
| snp_we | input | 1 | External access is a write |
| snp_addr | input | ADDR_W | External access address |
| snp_backoff | output | 1 | Abort and retry request to the external master |
| mem_rd_addr | output | ADDR_W | Memory read address for fills |
| mem_rdata | input | DATA_W | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The snoop path is tried with read and write snoops against Modified, Exclusive, Shared and absent lines. This separates a backoff with flush from a quiet state change, and it separates a Shared from an Invalid outcome, which shows later as a processor hit or miss. A second snoop held during the flush cycle shows that it is refused and leaves the lines it matches alone. The processor path runs through write-back and write-through writes on every clean and dirty state, which tells silent upgrades apart from memory writes. A set is then filled and re-touched in a chosen order, so that the tree victim falls on a dirty way and its write-back becomes visible.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef struct packed {
        logic             hit;
        logic [WAY_W-1:0] way;
        line_st_e         st;
    } probe_t;

    // tree: bit0 root (1 -> victim among ways 2/3), bit1 left pair, bit2 right pair
    function automatic logic [WAY_W-1:0] plru_victim(input logic [2:0] t);
        if (!t[0]) return t[1] ? 2'd1 : 2'd0;
        else       return t[2] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
        logic [2:0] n;
        n = t;
        if (!w[1]) begin
            n[0] = 1'b1;
            n[1] = (w == 2'd0);
        end else begin
            n[0] = 1'b0;
            n[2] = (w == 2'd2);
        end
        return n;
    endfunction

endpackage

// File: rtl/sfc_lookup.sv
module sfc_lookup
    import sfc_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0][1:0]        sts,
    input  logic [TAG_W-1:0]            key,
    output probe_t                      probe
);

    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = (sts[w] != 2'b00) && (tags[w] == key);
        end
    endgenerate

    always_comb begin
        probe = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                probe.hit = 1'b1;
                probe.way = WAY_W'(w);
                probe.st  = line_st_e'(sts[w]);
            end
        end
    end

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (rst) $onehot0(match)); // R12

endmodule

// File: rtl/sfc_flush_ctl.sv
module sfc_flush_ctl
    import sfc_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  logic             snp_we,
    input  probe_t           snp_probe,
    input  logic [IDX_W-1:0] snp_set,
    output logic             backoff,
    output logic             busy,
    output logic [IDX_W-1:0] fl_set,
    output logic [WAY_W-1:0] fl_way,
    output logic             fl_to_s
);

    logic hit_dirty;
    logic start;

    assign hit_dirty = snp_valid && snp_probe.hit && (snp_probe.st == ST_M);
    assign start     = hit_dirty && !busy;
    assign backoff   = snp_valid && (busy || hit_dirty);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            fl_set  <= '0;
            fl_way  <= '0;
            fl_to_s <= 1'b0;
        end else begin
            busy <= start;
            if (start) begin
                fl_set  <= snp_set;
                fl_way  <= snp_probe.way;
                fl_to_s <= !snp_we;
            end
        end
    end

endmodule

// File: rtl/snoop_flush_ctrl.sv
module snoop_flush_ctrl
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_wt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_backoff,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];
    line_st_e          st_q   [SETS][WAYS];
    logic [2:0]        plru_q [SETS];

    logic [IDX_W-1:0] cpu_set, snp_set;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    assign cpu_set = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_set = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    logic [WAYS-1:0][TAG_W-1:0] cpu_tags, snp_tags;
    logic [WAYS-1:0][1:0]       cpu_sts, snp_sts;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            cpu_tags[w] = tag_q[cpu_set][w];
            cpu_sts[w]  = st_q[cpu_set][w];
            snp_tags[w] = tag_q[snp_set][w];
            snp_sts[w]  = st_q[snp_set][w];
        end
    end

    probe_t cpu_probe, snp_probe;

    sfc_lookup #(.TAG_W(TAG_W)) u_cpu_lk (
        .clk(clk), .rst(rst), .tags(cpu_tags), .sts(cpu_sts), .key(cpu_tag), .probe(cpu_probe)
    );

    sfc_lookup #(.TAG_W(TAG_W)) u_snp_lk (
        .clk(clk), .rst(rst), .tags(snp_tags), .sts(snp_sts), .key(snp_tag), .probe(snp_probe)
    );

    logic             busy, fl_to_s;
    logic [IDX_W-1:0] fl_set;
    logic [WAY_W-1:0] fl_way;

    sfc_flush_ctl #(.IDX_W(IDX_W)) u_flush (
        .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_we(snp_we),
        .snp_probe(snp_probe), .snp_set(snp_set), .backoff(snp_backoff),
        .busy(busy), .fl_set(fl_set), .fl_way(fl_way), .fl_to_s(fl_to_s)
    );

    // victim: lowest Invalid way, else tree choice
    logic [WAY_W-1:0] vic_way;
    logic             vic_found;
    always_comb begin
        vic_way   = plru_victim(plru_q[cpu_set]);
        vic_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vic_found && st_q[cpu_set][w] == ST_I) begin
                vic_way   = WAY_W'(w);
                vic_found = 1'b1;
            end
        end
    end

    logic cpu_fire, wb_silent;
    assign cpu_ready   = !busy && !snp_valid;
    assign cpu_fire    = cpu_req && cpu_ready;
    assign cpu_hit     = cpu_probe.hit;
    assign cpu_rdata   = cpu_probe.hit ? data_q[cpu_set][cpu_probe.way] : mem_rdata;
    assign mem_rd_addr = cpu_addr;
    assign wb_silent   = cpu_probe.hit && !cpu_wt &&
                         (cpu_probe.st == ST_E || cpu_probe.st == ST_M);

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = cpu_addr;
        mem_wdata = cpu_wdata;
        if (busy) begin
            mem_we    = 1'b1;
            mem_waddr = {tag_q[fl_set][fl_way], fl_set};
            mem_wdata = data_q[fl_set][fl_way];
        end else if (cpu_fire) begin
            if (!cpu_we) begin
                if (!cpu_probe.hit && st_q[cpu_set][vic_way] == ST_M) begin
                    mem_we    = 1'b1;
                    mem_waddr = {tag_q[cpu_set][vic_way], cpu_set};
                    mem_wdata = data_q[cpu_set][vic_way];
                end
            end else if (!wb_silent) begin
                mem_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                plru_q[s] <= 3'b000;
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w]   <= ST_I;
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else if (busy) begin
            st_q[fl_set][fl_way] <= fl_to_s ? ST_S : ST_I;
        end else if (snp_valid) begin
            if (snp_probe.hit && snp_probe.st != ST_M) begin
                if (snp_we)
                    st_q[snp_set][snp_probe.way] <= ST_I;
                else if (snp_probe.st == ST_E)
                    st_q[snp_set][snp_probe.way] <= ST_S;
            end
        end else if (cpu_req) begin
            if (!cpu_we) begin
                if (cpu_probe.hit) begin
                    plru_q[cpu_set] <= plru_touch(plru_q[cpu_set], cpu_probe.way);
                end else begin
                    tag_q[cpu_set][vic_way]  <= cpu_tag;
                    data_q[cpu_set][vic_way] <= mem_rdata;
                    st_q[cpu_set][vic_way]   <= cpu_wt ? ST_S : ST_E;
                    plru_q[cpu_set]          <= plru_touch(plru_q[cpu_set], vic_way);
                end
            end else if (cpu_probe.hit) begin
                data_q[cpu_set][cpu_probe.way] <= cpu_wdata;
                st_q[cpu_set][cpu_probe.way]   <= wb_silent ? ST_M : ST_S;
                plru_q[cpu_set]                <= plru_touch(plru_q[cpu_set], cpu_probe.way);
            end
        end
    end

    AST_FLUSH_LINE_DIRTY: assert property (@(posedge clk) disable iff (rst)
        busy |-> st_q[fl_set][fl_way] == ST_M); // R3
    AST_FLUSH_CLEANS: assert property (@(posedge clk) disable iff (rst)
        busy |=> st_q[fl_set][fl_way] != ST_M); // R3
    AST_BACKOFF_BLOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
        snp_backoff |-> !cpu_ready); // R6
    AST_WB_HIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cpu_fire && cpu_we && wb_silent) |-> !mem_we); // R8
    AST_DIRTY_HIT_BACKS_OFF: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_probe.hit && snp_probe.st == ST_M) |-> snp_backoff); // R2

endmodule

// File: tb/sim_snoop_flush_ctrl.sv
module sim_snoop_flush_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 0, cpu_we = 0, cpu_wt = 0;
    logic [7:0]  cpu_addr = 0;
    logic [15:0] cpu_wdata = 0;
    logic        cpu_ready, cpu_hit;
    logic [15:0] cpu_rdata;
    logic        snp_valid = 0, snp_we = 0;
    logic [7:0]  snp_addr = 0;
    logic        snp_backoff;
    logic [7:0]  mem_rd_addr;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic [7:0]  mem_waddr;
    logic [15:0] mem_wdata;

    logic [15:0] mem [256];
    assign mem_rdata = mem[mem_rd_addr];

    always #10 clk = ~clk;

    snoop_flush_ctrl u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wt(cpu_wt),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .snp_valid(snp_valid),
        .snp_we(snp_we), .snp_addr(snp_addr), .snp_backoff(snp_backoff),
        .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model: 0 I, 1 S, 2 E, 3 M
    int mt [4][4];
    int ms [4][4];
    int md [4][4];
    int mp [4];
    bit m_busy = 0;
    int fs = 0, fw = 0;
    bit fsh = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int pick(int p);
        if ((p & 1) == 0) return ((p >> 1) & 1) != 0 ? 1 : 0;
        return ((p >> 2) & 1) != 0 ? 3 : 2;
    endfunction

    function automatic int touch(int p, int w);
        int n = p;
        if (w < 2) begin
            n = n | 1;
            n = (w == 0) ? (n | 2) : (n & ~2);
        end else begin
            n = n & ~1;
            n = (w == 2) ? (n | 4) : (n & ~4);
        end
        return n;
    endfunction

    task automatic step(string tag, bit req, bit we, bit wt, int a, int d,
                        bit sv, bit swe, int sa);
        int cs, ct, ss, stg, ch, sh, vic, fd;
        bit hitm, e_back, e_ready, fire, e_we;
        int e_rdata, e_wa, e_wd;
        @(negedge clk);
        cpu_req = req; cpu_we = we; cpu_wt = wt; cpu_addr = 8'(a); cpu_wdata = 16'(d);
        snp_valid = sv; snp_we = swe; snp_addr = 8'(sa);
        #2;
        cs = a % 4; ct = a / 4; ss = sa % 4; stg = sa / 4;
        ch = -1; sh = -1;
        for (int w = 0; w < 4; w++) begin
            if (ms[cs][w] != 0 && mt[cs][w] == ct) ch = w;
            if (ms[ss][w] != 0 && mt[ss][w] == stg) sh = w;
        end
        hitm    = sv && sh >= 0 && ms[ss][sh] == 3;
        e_back  = sv && (m_busy || hitm);
        e_ready = !m_busy && !sv;
        fd      = int'(mem[a]);
        e_rdata = ch >= 0 ? md[cs][ch] : fd;
        vic = -1;
        for (int w = 0; w < 4; w++) if (vic < 0 && ms[cs][w] == 0) vic = w;
        if (vic < 0) vic = pick(mp[cs]);
        fire = req && e_ready;
        e_we = 0; e_wa = 0; e_wd = 0;
        if (m_busy) begin
            e_we = 1; e_wa = mt[fs][fw] * 4 + fs; e_wd = md[fs][fw];
        end else if (fire) begin
            if (!we) begin
                if (ch < 0 && ms[cs][vic] == 3) begin
                    e_we = 1; e_wa = mt[cs][vic] * 4 + cs; e_wd = md[cs][vic];
                end
            end else if (!(ch >= 0 && !wt && ms[cs][ch] >= 2)) begin
                e_we = 1; e_wa = a; e_wd = d & 16'hFFFF;
            end
        end
        chk(tag, "snp_backoff", int'(snp_backoff), int'(e_back));
        chk(tag, "cpu_ready", int'(cpu_ready), int'(e_ready));
        chk(tag, "cpu_hit", int'(cpu_hit), (ch >= 0) ? 1 : 0);
        chk(tag, "cpu_rdata", int'(cpu_rdata), e_rdata);
        chk(tag, "mem_we", int'(mem_we), int'(e_we));
        if (e_we) begin
            chk(tag, "mem_waddr", int'(mem_waddr), e_wa);
            chk(tag, "mem_wdata", int'(mem_wdata), e_wd);
        end
        @(posedge clk);
        #1;
        if (e_we) mem[e_wa] = 16'(e_wd);
        if (m_busy) begin
            ms[fs][fw] = fsh ? 1 : 0;
            m_busy = 0;
        end else if (sv) begin
            if (sh >= 0) begin
                if (ms[ss][sh] == 3) begin
                    m_busy = 1; fs = ss; fw = sh; fsh = !swe;
                end else if (swe) ms[ss][sh] = 0;
                else if (ms[ss][sh] == 2) ms[ss][sh] = 1;
            end
        end else if (req) begin
            if (!we) begin
                if (ch >= 0) mp[cs] = touch(mp[cs], ch);
                else begin
                    mt[cs][vic] = ct; md[cs][vic] = fd; ms[cs][vic] = wt ? 1 : 2;
                    mp[cs] = touch(mp[cs], vic);
                end
            end else if (ch >= 0) begin
                md[cs][ch] = d & 16'hFFFF;
                ms[cs][ch] = (!wt && ms[cs][ch] >= 2) ? 3 : 1;
                mp[cs] = touch(mp[cs], ch);
            end
        end
    endtask

    task automatic rd(string tag, int a, bit wt);
        step(tag, 1, 0, wt, a, 0, 0, 0, 0);
    endtask
    task automatic wr(string tag, int a, int d, bit wt);
        step(tag, 1, 1, wt, a, d, 0, 0, 0);
    endtask
    task automatic snp(string tag, int a, bit swe);
        step(tag, 0, 0, 0, 0, 0, 1, swe, a);
    endtask
    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
        for (int s = 0; s < 4; s++) begin
            mp[s] = 0;
            for (int w = 0; w < 4; w++) begin
                mt[s][w] = 0; ms[s][w] = 0; md[s][w] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        idle("R1");
        snp("R1", 8'h20, 1);
        rd("R1", 8'h00, 0);            // R7 fill Exclusive
        rd("R7", 8'h00, 0);
        rd("R7", 8'h04, 1);            // fill Shared
        rd("R7", 8'h04, 0);
        // R8: write hits
        wr("R8", 8'h00, 16'h1111, 0);  // E -> M silent
        wr("R8", 8'h00, 16'h2222, 0);  // M stays M silent
        wr("R8", 8'h04, 16'h3333, 0);  // S -> memory write
        wr("R8", 8'h00, 16'h4444, 1);  // write-through on M
        wr("R8", 8'h00, 16'h5555, 0);  // now S -> memory write
        rd("R8", 8'h00, 0);
        // R2 / R3: read snoop on a Modified line
        rd("R7", 8'h08, 0);
        wr("R8", 8'h08, 16'hABCD, 0);
        snp("R2", 8'h08, 0);
        idle("R3");                    // flush cycle
        rd("R3", 8'h08, 0);            // now Shared: hit
        snp("R3", 8'h08, 0);           // Shared: no backoff
        snp("R5", 8'h08, 1);           // write snoop invalidates
        rd("R5", 8'h08, 0);            // miss, refetch from memory
        // R4: write snoop on Modified, second snoop during flush
        wr("R8", 8'h08, 16'h0F0F, 0);
        wr("R8", 8'h08, 16'h0E0E, 0);
        snp("R2", 8'h08, 1);
        snp("R4", 8'h04, 1);           // refused during flush
        rd("R4", 8'h04, 0);            // still present
        rd("R3", 8'h08, 0);            // Invalid after write snoop flush
        // R5: read snoop downgrades Exclusive
        rd("R7", 8'h0C, 0);
        snp("R5", 8'h0C, 0);
        wr("R5", 8'h0C, 16'h7777, 0);  // Shared -> memory write
        // R6: processor request blocked by a snoop
        step("R6", 1, 1, 0, 8'h40, 16'h9999, 1, 0, 8'h41);
        rd("R6", 8'h40, 0);
        // R9: write miss does not allocate
        wr("R9", 8'h31, 16'h5A5A, 0);
        rd("R9", 8'h31, 0);
        rd("R9", 8'h31, 0);
        // R10 / R11: tree victim with dirty write-back in set 2
        rd("R10", 8'h02, 0);
        rd("R10", 8'h06, 0);
        rd("R10", 8'h0A, 0);
        rd("R10", 8'h0E, 0);
        wr("R11", 8'h0A, 16'hBEEF, 0);
        rd("R11", 8'h0E, 0);
        rd("R11", 8'h02, 0);
        rd("R10", 8'h12, 0);           // victim way 2, dirty write-back
        rd("R10", 8'h0A, 0);
        rd("R10", 8'h16, 0);
        rd("R11", 8'h06, 0);
        // R12: repeated hits never duplicate a line
        rd("R12", 8'h12, 0);
        rd("R12", 8'h16, 0);
        idle("R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule